// File: doc/BRIEF.md
# Programmable Decimal Frequency Divider

This block divides a stream of clock-enable strobes by a programmable ratio N, from 3 to 15999. Each enabled clock moves a down-counter one step. When the counter reaches its terminal count, a zero detector reloads it from a 16-bit preset word and emits an output pulse. The counter is built from three cascaded decade digits (units, tens and hundreds) and a 4-bit binary top digit that carries the thousands.

A 3-bit mode selector and a latch-enable input choose among four behaviours:
- **Master preset** forces a continuous reload and keeps the output low.
- **Fixed** divides by 10000 and ignores the preset word.
- **Divide-by-N** produces one-cycle pulses.
- **Timer** holds the output high after a pulse for as long as latch-enable stays high. Counting carries on underneath.

Top module: `divn_counter`

## Requirements
- R1: While reset is asserted and after it is released, `div_out` is low. The counter starts empty, so the first enabled cycle in a counting mode reloads from the preset word and produces a pulse.
- R2: In divide-by-N mode (`mode_sel` from 1 to 6 with `latch_en` low), `div_out` is high for exactly one clock after every N-th enabled cycle, and low otherwise.
- R3: The preset word `jam` encodes N as follows. Bits [3:0] are the units, [7:4] the tens and [11:8] the hundreds, each in BCD. Bits [15:12] are the thousands in binary (0 to 15). N = 1000·th + 100·h + 10·t + u.
- R4: A BCD digit field above 9 is treated as 9.
- R5: A decoded N below 3 is treated as 3.
- R6: A cycle with `cnt_en` low does not advance the count and produces no new pulse.
- R7: With `mode_sel` = 3'b111, `jam` is ignored and one pulse appears per 10000 enabled cycles.
- R8: With `mode_sel` = 3'b000, the counter reloads N every cycle and `div_out` is low one clock later. After leaving this mode, the first pulse follows the N-th enabled cycle.
- R9: Timer mode is `mode_sel` from 1 to 6 with `latch_en` high. In this mode a pulse sets `div_out`, and `div_out` stays high until one clock after `latch_en` is sampled low.
- R10: Counting continues while the output is held, so pulses after the release keep the original N-cycle schedule.
- R11: A change to `jam` during a count takes effect only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Count strobe; one step per high cycle |
| mode_sel | input | 3 | Mode selector: 000 preset, 111 fixed /10000, others programmable |
| latch_en | input | 1 | In programmable modes, high selects timer behaviour |
| jam | input | 16 | Preset word: three BCD digits plus a binary thousands nibble |
| div_out | output | 1 | Divided output pulse, or held level in timer mode |

## Verification
Every internal fault shows up as a pulse in the wrong place. A digit that decrements wrongly or misses a borrow shifts the pulse by at least one enabled cycle, and it does so at the very next terminal count, so a short ratio shows it within a few cycles. A bad reload value only appears one full period later, so both small and four-digit ratios are run for at least two periods. A stuck hold flag is visible one clock after `latch_en` falls. A clamp or saturation error changes the period on the first reload after the offending preset word.

// File: rtl/divn_pkg.sv
package divn_pkg;
  localparam int DIG_W    = 4;
  localparam int NUM_DEC  = 3;
  localparam int TOP_W    = 4;
  localparam int DEC_MAX  = 9;
  localparam int MIN_N    = 3;
  localparam int FIX_TOP  = 10;
  localparam int MODE_W   = 3;
  localparam logic [MODE_W-1:0] PRESET_CODE = 3'b000;
  localparam logic [MODE_W-1:0] FIX_CODE    = 3'b111;

  typedef enum logic [1:0] {
    OP_PRESET = 2'd0,
    OP_DIVN   = 2'd1,
    OP_TIMER  = 2'd2,
    OP_FIX    = 2'd3
  } op_e;
endpackage

// File: rtl/divn_mode_dec.sv
module divn_mode_dec
  import divn_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              latch_i,
  output op_e               op_o
);
  always_comb begin
    if (mode_i == PRESET_CODE)   op_o = OP_PRESET;
    else if (mode_i == FIX_CODE) op_o = OP_FIX;
    else if (latch_i)            op_o = OP_TIMER;
    else                         op_o = OP_DIVN;
  end
endmodule

// File: rtl/divn_jam_dec.sv
module divn_jam_dec
  import divn_pkg::*;
#(
  parameter int DW   = DIG_W,
  parameter int ND   = NUM_DEC,
  parameter int TW   = TOP_W,
  localparam int JW  = ND*DW + TW
) (
  input  logic [JW-1:0]    jam_i,
  input  logic             fixed_i,
  output logic [ND*DW-1:0] dec_o,
  output logic [TW-1:0]    top_o
);
  localparam logic [DW-1:0] MAXV = DW'(DEC_MAX);
  localparam logic [DW-1:0] MINV = DW'(MIN_N);

  logic [ND*DW-1:0] sat_dec;
  logic             upper_zero;

  genvar g;
  generate
    for (g = 0; g < ND; g++) begin : g_sat
      assign sat_dec[g*DW +: DW] = (jam_i[g*DW +: DW] > MAXV) ? MAXV : jam_i[g*DW +: DW];
    end
  endgenerate

  always_comb begin
    upper_zero = (jam_i[JW-1 -: TW] == '0);
    for (int k = 1; k < ND; k++) begin
      if (sat_dec[k*DW +: DW] != '0) upper_zero = 1'b0;
    end
  end

  always_comb begin
    if (fixed_i) begin
      dec_o = '0;
      top_o = TW'(FIX_TOP);
    end else begin
      dec_o = sat_dec;
      top_o = jam_i[JW-1 -: TW];
      if (upper_zero && (sat_dec[DW-1:0] < MINV)) dec_o[DW-1:0] = MINV;
    end
  end
endmodule

// File: rtl/divn_digit.sv
module divn_digit #(
  parameter int W   = 4,
  parameter int MAX = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  output logic [W-1:0] val_o,
  output logic         borrow_o
);
  localparam logic [W-1:0] MAX_V = W'(MAX);

  logic [W-1:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (load_i)      val_d = load_val_i;
    else if (step_i) val_d = (val_q == '0) ? MAX_V : (val_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign val_o    = val_q;
  assign borrow_o = step_i & ~load_i & (val_q == '0);

  // R4
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    val_q <= MAX_V);
endmodule

// File: rtl/divn_out_ctrl.sv
module divn_out_ctrl
  import divn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_e  op_i,
  input  logic hit_i,
  output logic out_o
);
  logic pulse_q, pulse_d;
  logic hold_q, hold_d;

  always_comb begin
    pulse_d = (op_i != OP_PRESET) & hit_i;
    hold_d  = (op_i == OP_TIMER) & (hold_q | pulse_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      hold_q  <= hold_d;
    end
  end

  assign out_o = pulse_q | hold_q;

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  // R9
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && op_i == OP_TIMER) |=> out_o);
  // R8
  preset_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_PRESET) |=> !out_o);
endmodule

// File: rtl/divn_counter.sv
module divn_counter
  import divn_pkg::*;
#(
  parameter int DW  = DIG_W,
  parameter int ND  = NUM_DEC,
  parameter int TW  = TOP_W,
  localparam int JW = ND*DW + TW,
  localparam int CW = ND*DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              latch_en,
  input  logic [JW-1:0]     jam,
  output logic              div_out
);
  logic       rst_m, rst_s;
  op_e        op;
  logic [CW-1:0] reload_dec, dec_q;
  logic [TW-1:0] reload_top, top_q;
  logic [ND:0]   borrow;
  logic          top_borrow;
  logic          preset, terminal, load, hit;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  divn_mode_dec u_mode (
    .mode_i  (mode_sel),
    .latch_i (latch_en),
    .op_o    (op)
  );

  divn_jam_dec #(.DW(DW), .ND(ND), .TW(TW)) u_jam (
    .jam_i   (jam),
    .fixed_i (op == OP_FIX),
    .dec_o   (reload_dec),
    .top_o   (reload_top)
  );

  assign preset   = (op == OP_PRESET);
  assign terminal = (top_q == '0) && (dec_q[CW-1:DW] == '0) && (dec_q[DW-1:0] <= DW'(1));
  assign hit      = cnt_en & terminal;
  assign load     = preset | hit;
  assign borrow[0] = cnt_en & ~terminal & ~preset;

  genvar g;
  generate
    for (g = 0; g < ND; g++) begin : g_dec
      divn_digit #(.W(DW), .MAX(DEC_MAX)) u_dig (
        .clk        (clk),
        .rst_n      (rst_s),
        .load_i     (load),
        .load_val_i (reload_dec[g*DW +: DW]),
        .step_i     (borrow[g]),
        .val_o      (dec_q[g*DW +: DW]),
        .borrow_o   (borrow[g+1])
      );
    end
  endgenerate

  divn_digit #(.W(TW), .MAX((1 << TW) - 1)) u_top (
    .clk        (clk),
    .rst_n      (rst_s),
    .load_i     (load),
    .load_val_i (reload_top),
    .step_i     (borrow[ND]),
    .val_o      (top_q),
    .borrow_o   (top_borrow)
  );

  divn_out_ctrl u_out (
    .clk   (clk),
    .rst_n (rst_s),
    .op_i  (op),
    .hit_i (hit),
    .out_o (div_out)
  );

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !top_borrow);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!cnt_en && !preset) |=> $stable({top_q, dec_q}));
  // R11
  reload_chk: assert property (@(posedge clk) disable iff (!rst_s)
    load |=> ({top_q, dec_q} == $past({reload_top, reload_dec})));
endmodule

// File: tb/divn_counter_tb.sv
module divn_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_en;
  logic [2:0]  mode_sel;
  logic        latch_en;
  logic [15:0] jam;
  logic        div_out;

  int    errs = 0;
  int    checks = 0;
  int    cyc = 0;
  bit    done = 0;
  string req = "R1";

  int rem;
  bit m_pulse, m_hold, exp_out;

  always #10 clk = ~clk;

  divn_counter dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .mode_sel (mode_sel),
    .latch_en (latch_en),
    .jam      (jam),
    .div_out  (div_out)
  );

  function automatic int sat9(logic [3:0] d);
    return (d > 4'd9) ? 9 : int'(d);
  endfunction

  function automatic int ratio(logic [15:0] j, logic [2:0] m);
    int n;
    if (m == 3'b111) return 10000;
    n = int'(j[15:12]) * 1000 + sat9(j[11:8]) * 100 + sat9(j[7:4]) * 10 + sat9(j[3:0]);
    return (n < 3) ? 3 : n;
  endfunction

  // reference model, updated from the requirements at each clock
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      rem = 0; m_pulse = 0; m_hold = 0;
    end else begin
      bit pre, tim, term;
      int nv;
      pre = (mode_sel == 3'b000);
      tim = !pre && (mode_sel != 3'b111) && latch_en;
      nv  = ratio(jam, mode_sel);
      if (pre) begin
        rem = nv; m_pulse = 0; m_hold = 0;
      end else begin
        term    = cnt_en && (rem <= 1);
        m_pulse = term;
        m_hold  = tim && (m_hold || term);
        if (cnt_en) rem = term ? nv : rem - 1;
      end
    end
    exp_out = m_pulse | m_hold;
  end

  task automatic chk();
    checks++;
    if (div_out !== exp_out) begin
      errs++;
      $display("FAIL %s: cycle %0d div_out=%0b expected %0b", req, cyc, div_out, exp_out);
    end
  endtask

  task automatic tick(int n, int en_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk();
      cnt_en = ($urandom_range(0, 99) < en_pct);
    end
  endtask

  initial begin
    #(190000 * 20);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c3a5));
    rst_n = 0; cnt_en = 0; mode_sel = 3'd1; latch_en = 0; jam = 16'h0005;
    // R1: low in reset, and low after release while idle
    req = "R1"; tick(4, 0);
    @(negedge clk); rst_n = 1;
    tick(6, 0);
    // R1: first enable pulses, then R2 period of 5
    req = "R2"; tick(40, 100);
    // R5: small ratios clamp to 3
    req = "R5"; jam = 16'h0001; tick(20, 100);
    jam = 16'h0000; tick(20, 100);
    // R4: over-range BCD digits saturate (0x00AF -> 99)
    req = "R4"; jam = 16'h00AF; tick(220, 100);
    // R6: gaps in the enable stream
    req = "R6"; jam = 16'h0007; tick(20, 100); tick(30, 0); tick(80, 40);
    // R8: master preset, then resume
    req = "R8"; mode_sel = 3'b000; jam = 16'h0004; tick(15, 60);
    mode_sel = 3'd2; tick(30, 100);
    // R9: timer hold, R10: schedule kept after release
    req = "R9"; mode_sel = 3'd3; jam = 16'h0006; latch_en = 1; tick(30, 100);
    req = "R10"; latch_en = 0; tick(30, 100);
    // R11: preset word changed mid-count
    req = "R11"; jam = 16'h0020; tick(25, 100); jam = 16'h0007; tick(40, 100);
    // R3: four-digit ratio over two periods
    req = "R3"; jam = 16'h1234; tick(2600, 100);
    // R7: fixed mode ignores the preset word
    req = "R7"; mode_sel = 3'b111; jam = 16'h0003; tick(20300, 100);
    // R3: maximum ratio 15999, two periods
    req = "R3"; mode_sel = 3'd5; jam = 16'hF999; tick(32200, 100);
    // random mix of modes, ratios, latch and enable density
    req = "R2";
    for (int s = 0; s < 40; s++) begin
      mode_sel = 3'($urandom_range(0, 7));
      latch_en = ($urandom_range(0, 3) == 0);
      jam      = {8'h00, 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15))};
      req      = latch_en ? "R9" : "R2";
      tick(120, $urandom_range(30, 100));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule